// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This block takes a single pulse-width-modulated drive level and turns it into two complementary gate enables for one leg of a half or full bridge. The high-side enable follows the input and the low-side enable follows its inverse. The two enables are never active at the same time. A turn-off is passed straight through. A turn-on is held back for a programmable number of clock cycles, so every switching event has a window in which both switches are off. A short dead time is not the same as a delayed copy of the signal: shifting both edges would widen the overlap at the trailing edge, so here only the rising edge of each enable moves and both active phases shrink.

The input level first passes through a two-flop synchronizer. A state machine with five states then acts on the synchronized level:

- `ST_OFF`: disabled.
- `ST_WAIT_HI` and `ST_WAIT_LO`: a dead window before one side turns on.
- `ST_HI_ON` and `ST_LO_ON`: one side is conducting.

The transitions are:

- **wake**: `ST_OFF` to `ST_WAIT_HI` or `ST_WAIT_LO`, chosen by the level while enabled.
- **expire**: a wait state to its on state, when the dead-time timer runs out.
- **flip**: an on state to the opposite wait state, when the level changes.
- **abort**: a wait state to the opposite wait state, when the level changes before the timer expires.
- **halt**: any state to `ST_OFF`, when the enable is low or reset is applied.

The dead time is a cycle count on an input port. At a 100 MHz clock, a nominal 500 ns is a count of 50, which is ample for switching rates up to 250 kHz.

Top module: `bridge_deadband`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block goes to `ST_OFF`, and `hs_on` and `ls_on` are both 0 from that edge on.
- R2: A change of `pwm_in` made between two edges switches off the conducting enable on the third rising edge after the change, whatever the value of `dead_cycles`.
- R3: After a turn-off, the other enable turns on exactly max(`dead_cycles`,1) cycles later, so a value of 0 behaves like 1.
- R4: `hs_on` and `ls_on` are never 1 in the same cycle.
- R5: If the level flips back before a pending turn-on expires, that turn-on is cancelled. The opposite wait starts a fresh full count, and the cancelled side never turns on.
- R6: While `enable` is 0, both enables are 0 in the same cycle, with no clock edge needed, and toggling `pwm_in` has no effect on them.
- R7: When `enable` returns to 1, the side that matches the synchronized level turns on max(`dead_cycles`,1) cycles after the first edge that sees `enable` high. The count starts fresh.
- R8: Polarity: `pwm_in` = 1 selects the high side (`hs_on`), and `pwm_in` = 0 selects the low side (`ls_on`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Drive level, asynchronous to `clk` |
| enable | input | 1 | Global enable; low forces both outputs off |
| dead_cycles | input | CNT_W | Dead time in clock cycles (0 treated as 1) |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
A wrong state or a stuck timer in this block shows up at the ports within one dead window. Three symptoms are possible: an enable that rises a cycle early or late relative to the third-edge turn-off, an enable that never rises after an aborted pulse, or both enables high at once. The bench predicts each output cycle by cycle from the input timing alone, using three edges for turn-off and the count for turn-on. Any shift of even one cycle in either edge therefore fails the comparison in the cycle where it appears.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_WAIT_HI = 3'd1,
        ST_HI_ON   = 3'd2,
        ST_WAIT_LO = 3'd3,
        ST_LO_ON   = 3'd4
    } db_state_e;

endpackage

// File: rtl/deadband_sync.sv
module deadband_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= 1'b0;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/deadband_timer.sv
module deadband_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // First cycle of a window holds 1, so a limit of 0 or 1 both expire at once.
    assign expired = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (restart) cnt <= CNT_W'(1);
        else if (!expired) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/deadband_fsm.sv
module deadband_fsm
    import deadband_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic level,
    input  logic expired,
    output logic restart,
    output logic hs_act,
    output logic ls_act
);
    db_state_e state, state_n;

    always_comb begin
        state_n = state;
        if (!en) begin
            state_n = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     state_n = level ? ST_WAIT_HI : ST_WAIT_LO;
                ST_WAIT_HI: begin
                    if (!level)       state_n = ST_WAIT_LO;
                    else if (expired) state_n = ST_HI_ON;
                end
                ST_HI_ON:   if (!level) state_n = ST_WAIT_LO;
                ST_WAIT_LO: begin
                    if (level)        state_n = ST_WAIT_HI;
                    else if (expired) state_n = ST_LO_ON;
                end
                ST_LO_ON:   if (level) state_n = ST_WAIT_HI;
                default:    state_n = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_n;
    end

    always_comb begin
        restart = ((state_n == ST_WAIT_HI) && (state != ST_WAIT_HI)) ||
                  ((state_n == ST_WAIT_LO) && (state != ST_WAIT_LO));
        hs_act  = (state == ST_HI_ON);
        ls_act  = (state == ST_LO_ON);
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hs_act && ls_act));

    a_r3_gap_hi: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_act) |-> !$past(ls_act));

    a_r3_gap_lo: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_act) |-> !$past(hs_act));

    a_r2_off_hi: assert property (@(posedge clk) disable iff (rst)
        (hs_act && !level) |=> !hs_act);

    a_r5_cancel_hi: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_HI && !level && en) |=> (state == ST_WAIT_LO && !hs_act));
endmodule

// File: rtl/bridge_deadband.sv
module bridge_deadband #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             enable,
    input  logic [CNT_W-1:0] dead_cycles,
    output logic             hs_on,
    output logic             ls_on
);
    logic level, restart, expired, hs_act, ls_act;

    deadband_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(pwm_in), .q_sync(level)
    );

    deadband_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .restart(restart),
        .limit(dead_cycles), .expired(expired)
    );

    deadband_fsm u_fsm (
        .clk(clk), .rst(rst), .en(enable), .level(level),
        .expired(expired), .restart(restart),
        .hs_act(hs_act), .ls_act(ls_act)
    );

    // Disable acts without waiting for a clock edge.
    assign hs_on = hs_act & enable;
    assign ls_on = ls_act & enable;

    a_r6_disable_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!hs_on && !ls_on));
endmodule

// File: tb/test_bridge_deadband.sv
module test_bridge_deadband;
    localparam int PERIOD = 10;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b0;
    logic enable = 1'b1;
    logic [CW-1:0] dead_cycles = CW'(5);
    logic hs_on, ls_on;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int n_overlap = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    hs;
        bit    ls;
        string tag;
    } exp_t;
    exp_t sb[$];

    bridge_deadband #(.CNT_W(CW), .SYNC_STAGES(2)) i_bridge_deadband (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .enable(enable),
        .dead_cycles(dead_cycles), .hs_on(hs_on), .ls_on(ls_on)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit h, input bit l, input string tag);
        n_run++;
        if (hs_on !== h || ls_on !== l) begin
            n_fail++;
            $display("FAIL %s: cycle %0d hs=%b ls=%b expected hs=%b ls=%b",
                     tag, cyc, hs_on, ls_on, h, l);
        end
    endtask

    // Monitor: compares scoreboard entries due in this cycle.
    always @(negedge clk) begin
        #2;
        if (!rst && hs_on === 1'b1 && ls_on === 1'b1) n_overlap++;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.at < cyc) begin
                n_run++; n_fail++;
                $display("FAIL %s: entry for cycle %0d seen late at %0d", e.tag, e.at, cyc);
            end else begin
                check(e.hs, e.ls, e.tag);
            end
        end
    end

    task automatic push_span(input int a, input int b, input bit h, input bit l, input string tag);
        for (int k = a; k <= b; k++) sb.push_back('{k, h, l, tag});
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Drives a level change and predicts both enables around it.
    task automatic edge_case(input bit v, input int d, input string tag);
        int de, c;
        de = (d == 0) ? 1 : d;
        @(negedge clk);
        pwm_in = v;
        c = cyc;
        push_span(c + 1, c + 2, !v, v, {tag, " R2 before"});
        push_span(c + 3, c + 2 + de, 1'b0, 1'b0, {tag, " R3 dead"});
        sb.push_back('{c + 3 + de, v, !v, {tag, " R8 on"}});
        drain();
    endtask

    initial begin
        int c, de;
        // R1: reset holds both low
        repeat (3) begin
            @(negedge clk); #2; check(1'b0, 1'b0, "R1 in reset");
        end
        @(negedge clk);
        rst = 1'b0;
        c = cyc;
        push_span(c + 1, c + 5, 1'b0, 1'b0, "R7 wake count");
        sb.push_back('{c + 6, 1'b0, 1'b1, "R8 low side after wake"});
        drain();

        edge_case(1'b1, 5, "d5 rise");
        edge_case(1'b0, 5, "d5 fall");
        dead_cycles = CW'(12);
        edge_case(1'b1, 12, "d12 rise");
        edge_case(1'b0, 12, "d12 fall");
        dead_cycles = CW'(0);
        edge_case(1'b1, 0, "d0 rise R3 zero");
        dead_cycles = CW'(1);
        edge_case(1'b0, 1, "d1 fall");

        // R5: short pulse aborts pending high-side turn-on
        dead_cycles = CW'(10);
        @(negedge clk);
        pwm_in = 1'b1;
        c = cyc;
        push_span(c + 1, c + 2, 1'b0, 1'b1, "R5 before");
        push_span(c + 3, c + 14, 1'b0, 1'b0, "R5 cancelled");
        sb.push_back('{c + 15, 1'b0, 1'b1, "R5 restart full count"});
        repeat (2) @(negedge clk);
        pwm_in = 1'b0;
        drain();

        // R6: disable acts in the same cycle, input ignored
        dead_cycles = CW'(4);
        edge_case(1'b1, 4, "d4 rise");
        @(negedge clk);
        enable = 1'b0;
        #1; check(1'b0, 1'b0, "R6 immediate off");
        pwm_in = 1'b0;
        repeat (4) begin
            @(negedge clk); #2; check(1'b0, 1'b0, "R6 ignore low");
        end
        pwm_in = 1'b1;
        repeat (5) begin
            @(negedge clk); #2; check(1'b0, 1'b0, "R6 ignore high");
        end
        // R7: fresh count after re-enable
        @(negedge clk);
        enable = 1'b1;
        c = cyc;
        de = 4;
        push_span(c + 1, c + de, 1'b0, 1'b0, "R7 fresh dead");
        sb.push_back('{c + 1 + de, 1'b1, 1'b0, "R7 on after enable"});
        drain();

        // R1: reset during conduction
        @(negedge clk);
        rst = 1'b1;
        #2; check(1'b1, 1'b0, "R1 before reset edge");
        @(negedge clk); #2; check(1'b0, 1'b0, "R1 reset mid-run");

        // R4: no cycle with both enables high
        n_run++;
        if (n_overlap != 0) begin
            n_fail++;
            $display("FAIL R4: overlap cycles=%0d expected 0", n_overlap);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule